// File: doc/BRIEF.md
# Banked Register-File Address Mapper

This block sits between an instruction decoder and the data RAM of a small 8-bit core. It turns a register-file reference into one flat physical RAM address. The data space has four banks of 128 bytes each. With direct addressing, a 7-bit offset from the instruction is joined to a 2-bit bank select. With indirect addressing, an 8-bit pointer is joined to one extra bank bit, which gives a 9-bit address. The top two bits of that address pick the bank.

Several locations are the same storage seen from different banks. The upper 16 offsets of every bank reach one shared block. A configurable set of low special registers reaches its bank 0 copy from any bank. Locations with no storage behind them report a miss. A miss gives a zero address, a zero read value and no write strobe. The result is registered and appears one cycle after the request. The read data path is gated by the registered hit.

Top module: `bank_addr_mapper`

## Requirements
- R1: In direct mode (`req_ind`=0), an implemented non-aliased location maps to `map_addr` = {`dir_bank`, `dir_off`}. Bank 0 implements its special offsets 00h–0Bh and bank 1 implements 01h and 05h–09h (default parameters). General RAM at offsets 20h–6Fh exists in banks 0 and 1 only.
- R2: In indirect mode (`req_ind`=1), the location is {`ind_hi`, `ind_ptr`}. Bit 8 and bit 7 of that value are the bank and bits 6:0 are the offset. `dir_off` and `dir_bank` have no effect.
- R3: Offsets 70h–7Fh map to {2'b00, offset} from every bank.
- R4: The mirrored offsets 00h, 02h, 03h, 04h, 0Ah and 0Bh map to {2'b00, offset} from every bank.
- R5: A location that is not implemented gives `map_hit`=0, `map_addr`=0 and `rd_data`=0. This includes offsets 0Ch–1Fh of bank 0, offsets 20h–6Fh of banks 2 and 3, and the non-mirrored special offsets of banks 2 and 3.
- R6: `ram_we` is 1 only for a write request that hits. A write to an unimplemented location is dropped without any error indication.
- R7: `map_vld`, `map_hit`, `map_addr` and `ram_we` take their new values one clock after the request is sampled. With `req_vld`=0 they return to 0 on the next clock.
- R8: While `rst_n` is low, all registered outputs are 0. This holds even if a request is pending.
- R9: `rd_data` passes `ram_rdata` straight through during a registered read hit and is 0 otherwise, including during a write hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Access request this cycle |
| req_wr | input | 1 | 1 for a write, 0 for a read |
| req_ind | input | 1 | 1 selects indirect addressing |
| dir_off | input | 7 | Offset from the instruction |
| dir_bank | input | 2 | Bank select for direct addressing |
| ind_ptr | input | 8 | Pointer for indirect addressing |
| ind_hi | input | 1 | Extra bank bit for indirect addressing |
| ram_rdata | input | 8 | Read data from the RAM at `map_addr` |
| map_vld | output | 1 | Registered request valid |
| map_addr | output | 9 | Physical RAM address, 0 on a miss |
| map_hit | output | 1 | Location is implemented |
| ram_we | output | 1 | Gated RAM write strobe |
| rd_data | output | 8 | Gated read data |

## Verification
The bench drives every request on a falling edge. The registered outputs `map_vld`, `map_hit`, `map_addr` and `ram_we` change at the following rising edge. They are therefore sampled on the next falling edge, one cycle after the stimulus.

One extra probe is taken a moment after driving the first request. It confirms that nothing has moved early.

`rd_data` is combinational from the registered hit and `ram_rdata`. The bench checks it in the same sample window, and also after changing `ram_rdata` mid-cycle, to show that it follows with no register in the path.

Reset is checked asynchronously, shortly after `rst_n` falls while a hitting request is held.

// File: rtl/dmap_pkg.sv
package dmap_pkg;

    // Region classes for an in-bank offset
    typedef enum logic [1:0] {
        RGN_SPECIAL = 2'd0,
        RGN_GENERAL = 2'd1,
        RGN_SHARED  = 2'd2
    } region_e;

endpackage

// File: rtl/dmap_bank_sel.sv
// Picks bank and offset from the direct or the indirect source.
module dmap_bank_sel #(
    parameter int OFF_W  = 7,
    parameter int BANK_W = 2,
    localparam int PTR_W = OFF_W + 1,
    localparam int HI_W  = BANK_W - 1
) (
    input  logic              use_ind,
    input  logic [OFF_W-1:0]  dir_off,
    input  logic [BANK_W-1:0] dir_bank,
    input  logic [PTR_W-1:0]  ind_ptr,
    input  logic [HI_W-1:0]   ind_hi,
    output logic [BANK_W-1:0] bank,
    output logic [OFF_W-1:0]  off
);

    logic [HI_W+PTR_W-1:0] ind_full;

    always_comb begin
        ind_full = {ind_hi, ind_ptr};
        if (use_ind) begin
            bank = ind_full[HI_W+PTR_W-1 -: BANK_W];
            off  = ind_full[OFF_W-1:0];
        end else begin
            bank = dir_bank;
            off  = dir_off;
        end
    end

endmodule

// File: rtl/dmap_region_decode.sv
// Classifies a bank/offset pair and forms the physical address.
module dmap_region_decode
    import dmap_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int OFF_W     = 7,
    parameter int SFR_SPAN  = 32,
    parameter int SHARED_LO = 112,
    parameter int GPR_BANKS = 2,
    parameter logic [SFR_SPAN-1:0] MIRROR_MASK = 32'h0000_0C1D,
    parameter logic [NUM_BANKS-1:0][SFR_SPAN-1:0] SFR_IMPL =
        {32'h0, 32'h0, 32'h0000_03E2, 32'h0000_0FFF},
    localparam int BANK_W = $clog2(NUM_BANKS),
    localparam int SFR_W  = $clog2(SFR_SPAN),
    localparam int ADDR_W = BANK_W + OFF_W
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [OFF_W-1:0]  off,
    output logic              impl,
    output logic [ADDR_W-1:0] phys
);

    region_e          region;
    logic [SFR_W-1:0] sfr_idx;
    logic [NUM_BANKS-1:0] own_sfr;
    logic             is_mirror;
    logic             own_hit;
    logic             gpr_hit;

    assign sfr_idx = off[SFR_W-1:0];

    // One match term per bank for its own special registers
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign own_sfr[b] = (int'(bank) == b) && SFR_IMPL[b][sfr_idx];
    end

    always_comb begin
        if (int'(off) >= SHARED_LO)
            region = RGN_SHARED;
        else if (int'(off) < SFR_SPAN)
            region = RGN_SPECIAL;
        else
            region = RGN_GENERAL;

        is_mirror = (region == RGN_SPECIAL) && MIRROR_MASK[sfr_idx];
        own_hit   = (region == RGN_SPECIAL) && (|own_sfr);
        gpr_hit   = (region == RGN_GENERAL) && (int'(bank) < GPR_BANKS);

        impl = 1'b0;
        phys = '0;
        if (region == RGN_SHARED || is_mirror) begin
            impl = 1'b1;
            phys = {{BANK_W{1'b0}}, off};
        end else if (own_hit || gpr_hit) begin
            impl = 1'b1;
            phys = {bank, off};
        end
    end

endmodule

// File: rtl/bank_addr_mapper.sv
// Banked register-file address mapper, registered result.
module bank_addr_mapper #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_SIZE = 128,
    parameter int SFR_SPAN  = 32,
    parameter int SHARED_LO = 112,
    parameter int GPR_BANKS = 2,
    parameter logic [SFR_SPAN-1:0] MIRROR_MASK = 32'h0000_0C1D,
    parameter logic [NUM_BANKS-1:0][SFR_SPAN-1:0] SFR_IMPL =
        {32'h0, 32'h0, 32'h0000_03E2, 32'h0000_0FFF},
    parameter int DATA_W    = 8,
    localparam int OFF_W  = $clog2(BANK_SIZE),
    localparam int BANK_W = $clog2(NUM_BANKS),
    localparam int ADDR_W = OFF_W + BANK_W,
    localparam int PTR_W  = OFF_W + 1,
    localparam int HI_W   = BANK_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic              req_wr,
    input  logic              req_ind,
    input  logic [OFF_W-1:0]  dir_off,
    input  logic [BANK_W-1:0] dir_bank,
    input  logic [PTR_W-1:0]  ind_ptr,
    input  logic [HI_W-1:0]   ind_hi,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              map_vld,
    output logic [ADDR_W-1:0] map_addr,
    output logic              map_hit,
    output logic              ram_we,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic              vld;
        logic              hit;
        logic              wr;
        logic              we;
        logic [ADDR_W-1:0] addr;
    } map_state_t;

    logic [BANK_W-1:0] sel_bank;
    logic [OFF_W-1:0]  sel_off;
    logic              dec_impl;
    logic [ADDR_W-1:0] dec_phys;
    map_state_t        st_d, st_q;

    dmap_bank_sel #(
        .OFF_W  (OFF_W),
        .BANK_W (BANK_W)
    ) u_bank_sel (
        .use_ind  (req_ind),
        .dir_off  (dir_off),
        .dir_bank (dir_bank),
        .ind_ptr  (ind_ptr),
        .ind_hi   (ind_hi),
        .bank     (sel_bank),
        .off      (sel_off)
    );

    dmap_region_decode #(
        .NUM_BANKS   (NUM_BANKS),
        .OFF_W       (OFF_W),
        .SFR_SPAN    (SFR_SPAN),
        .SHARED_LO   (SHARED_LO),
        .GPR_BANKS   (GPR_BANKS),
        .MIRROR_MASK (MIRROR_MASK),
        .SFR_IMPL    (SFR_IMPL)
    ) u_decode (
        .bank (sel_bank),
        .off  (sel_off),
        .impl (dec_impl),
        .phys (dec_phys)
    );

    always_comb begin
        st_d      = '0;
        st_d.vld  = req_vld;
        st_d.wr   = req_vld && req_wr;
        st_d.hit  = req_vld && dec_impl;
        st_d.we   = req_vld && req_wr && dec_impl;
        st_d.addr = (req_vld && dec_impl) ? dec_phys : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign map_vld  = st_q.vld;
    assign map_hit  = st_q.hit;
    assign map_addr = st_q.addr;
    assign ram_we   = st_q.we;
    assign rd_data  = (st_q.hit && !st_q.wr) ? ram_rdata : '0;

endmodule

// File: rtl/bank_addr_mapper_sva.sv
module bank_addr_mapper_sva #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_SIZE = 128,
    parameter int SFR_SPAN  = 32,
    parameter int SHARED_LO = 112,
    parameter int GPR_BANKS = 2,
    parameter logic [SFR_SPAN-1:0] MIRROR_MASK = 32'h0000_0C1D,
    parameter int DATA_W    = 8,
    localparam int OFF_W  = $clog2(BANK_SIZE),
    localparam int BANK_W = $clog2(NUM_BANKS),
    localparam int ADDR_W = OFF_W + BANK_W,
    localparam int PTR_W  = OFF_W + 1,
    localparam int HI_W   = BANK_W - 1,
    localparam int SFR_W  = $clog2(SFR_SPAN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_vld,
    input logic              req_wr,
    input logic              req_ind,
    input logic [OFF_W-1:0]  dir_off,
    input logic [BANK_W-1:0] dir_bank,
    input logic [PTR_W-1:0]  ind_ptr,
    input logic [HI_W-1:0]   ind_hi,
    input logic [DATA_W-1:0] ram_rdata,
    input logic              map_vld,
    input logic [ADDR_W-1:0] map_addr,
    input logic              map_hit,
    input logic              ram_we,
    input logic [DATA_W-1:0] rd_data
);

    logic dir_mirror;
    logic dir_gpr;
    logic ind_gpr;
    logic [BANK_W-1:0] ind_bank;

    always_comb begin
        ind_bank   = {ind_hi, ind_ptr[PTR_W-1]};
        dir_mirror = !req_ind && (int'(dir_off) < SFR_SPAN) &&
                     MIRROR_MASK[dir_off[SFR_W-1:0]];
        dir_gpr    = !req_ind && (int'(dir_off) >= SFR_SPAN) &&
                     (int'(dir_off) < SHARED_LO) && (int'(dir_bank) < GPR_BANKS);
        ind_gpr    = req_ind && (int'(ind_ptr[OFF_W-1:0]) >= SFR_SPAN) &&
                     (int'(ind_ptr[OFF_W-1:0]) < SHARED_LO) &&
                     (int'(ind_bank) < GPR_BANKS);
    end

    AST_DIRECT_GPR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && dir_gpr) |=> (map_hit && map_addr == {$past(dir_bank), $past(dir_off)})); // R1
    AST_INDIRECT_GPR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && ind_gpr) |=> (map_hit && map_addr == {$past(ind_hi), $past(ind_ptr)})); // R2
    AST_SHARED_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        (map_hit && int'(map_addr[OFF_W-1:0]) >= SHARED_LO) |-> (map_addr[ADDR_W-1:OFF_W] == '0)); // R3
    AST_MIRROR_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && dir_mirror) |=> (map_hit && map_addr[ADDR_W-1:OFF_W] == '0)); // R4
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !map_hit |-> (map_addr == '0 && rd_data == '0)); // R5
    AST_WE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> map_hit); // R6
    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> map_vld); // R7
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!map_vld && !map_hit && !ram_we)); // R7
    AST_READ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (map_hit && !ram_we && $stable(ram_rdata) && $past(!req_wr)) |-> rd_data == ram_rdata); // R9

endmodule

bind bank_addr_mapper bank_addr_mapper_sva #(
    .NUM_BANKS   (NUM_BANKS),
    .BANK_SIZE   (BANK_SIZE),
    .SFR_SPAN    (SFR_SPAN),
    .SHARED_LO   (SHARED_LO),
    .GPR_BANKS   (GPR_BANKS),
    .MIRROR_MASK (MIRROR_MASK),
    .DATA_W      (DATA_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vld   (req_vld),
    .req_wr    (req_wr),
    .req_ind   (req_ind),
    .dir_off   (dir_off),
    .dir_bank  (dir_bank),
    .ind_ptr   (ind_ptr),
    .ind_hi    (ind_hi),
    .ram_rdata (ram_rdata),
    .map_vld   (map_vld),
    .map_addr  (map_addr),
    .map_hit   (map_hit),
    .ram_we    (ram_we),
    .rd_data   (rd_data)
);

// File: tb/bank_addr_mapper_test.sv
module bank_addr_mapper_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_vld, req_wr, req_ind;
    logic [6:0] dir_off;
    logic [1:0] dir_bank;
    logic [7:0] ind_ptr;
    logic [0:0] ind_hi;
    logic [7:0] ram_rdata;
    logic       map_vld, map_hit, ram_we;
    logic [8:0] map_addr;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bank_addr_mapper uut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
        .req_ind(req_ind), .dir_off(dir_off), .dir_bank(dir_bank),
        .ind_ptr(ind_ptr), .ind_hi(ind_hi), .ram_rdata(ram_rdata),
        .map_vld(map_vld), .map_addr(map_addr), .map_hit(map_hit),
        .ram_we(ram_we), .rd_data(rd_data)
    );

    // {wr, ind, off[6:0], bank[1:0], ptr[7:0], hi, exp_hit, exp_addr[8:0]}
    localparam int NV = 17;
    localparam logic [29:0] VEC [NV] = '{
        {1'b0,1'b0,7'h25,2'd1,8'h00,1'b0,1'b1,9'h0A5}, // R1 GPR bank1
        {1'b0,1'b0,7'h40,2'd0,8'h00,1'b0,1'b1,9'h040}, // R1 GPR bank0
        {1'b0,1'b0,7'h40,2'd2,8'h00,1'b0,1'b0,9'h000}, // R5 GPR bank2
        {1'b0,1'b0,7'h75,2'd3,8'h00,1'b0,1'b1,9'h075}, // R3 shared
        {1'b0,1'b0,7'h7F,2'd2,8'h00,1'b0,1'b1,9'h07F}, // R3 shared top
        {1'b0,1'b0,7'h03,2'd3,8'h00,1'b0,1'b1,9'h003}, // R4 mirror
        {1'b0,1'b0,7'h0A,2'd1,8'h00,1'b0,1'b1,9'h00A}, // R4 mirror
        {1'b0,1'b0,7'h05,2'd1,8'h00,1'b0,1'b1,9'h085}, // R1 bank1 own
        {1'b0,1'b0,7'h05,2'd0,8'h00,1'b0,1'b1,9'h005}, // R1 bank0 own
        {1'b0,1'b0,7'h05,2'd2,8'h00,1'b0,1'b0,9'h000}, // R5 bank2 special
        {1'b0,1'b0,7'h1F,2'd0,8'h00,1'b0,1'b0,9'h000}, // R5 bank0 hole
        {1'b0,1'b1,7'h7F,2'd3,8'hA5,1'b0,1'b1,9'h0A5}, // R2 direct ignored
        {1'b0,1'b1,7'h25,2'd1,8'h30,1'b1,1'b0,9'h000}, // R2 bank2 GPR miss
        {1'b0,1'b1,7'h00,2'd0,8'hF0,1'b1,1'b1,9'h070}, // R2 shared
        {1'b0,1'b1,7'h40,2'd1,8'h84,1'b0,1'b1,9'h004}, // R2 mirror
        {1'b1,1'b0,7'h40,2'd3,8'h00,1'b0,1'b0,9'h000}, // R6 dropped write
        {1'b1,1'b0,7'h20,2'd1,8'h00,1'b0,1'b1,9'h0A0}  // R6 write hit
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_vld = 1'b0; req_wr = 1'b0; req_ind = 1'b0;
        dir_off = '0; dir_bank = '0; ind_ptr = '0; ind_hi = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle_inputs();
        ram_rdata = 8'h5A;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 reset vld", 32'(map_vld), 0);
        chk("R8 reset addr", 32'(map_addr), 0);
        chk("R8 reset hit/we", {30'b0, map_hit, ram_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 idle vld", 32'(map_vld), 0);

        for (int i = 0; i < NV; i++) begin
            logic [29:0] v;
            logic        ehit, ewr;
            v = VEC[i];
            req_vld = 1'b1;
            req_wr = v[29]; req_ind = v[28]; dir_off = v[27:21];
            dir_bank = v[20:19]; ind_ptr = v[18:11]; ind_hi = v[10];
            ehit = v[9]; ewr = v[29];
            if (i == 0) begin
                #1;
                chk("R7 no early update", {30'b0, map_vld, map_hit}, 0);
            end
            @(negedge clk);
            chk($sformatf("vec%0d R7 vld", i), 32'(map_vld), 1);
            chk($sformatf("vec%0d R1-R5 hit", i), 32'(map_hit), 32'(ehit));
            chk($sformatf("vec%0d R1-R5 addr", i), 32'(map_addr), 32'(v[8:0]));
            chk($sformatf("vec%0d R6 we", i), 32'(ram_we), 32'(ehit && ewr));
            chk($sformatf("vec%0d R9 rd_data", i), 32'(rd_data),
                (ehit && !ewr) ? 32'h5A : 32'h0);
        end

        // R9: read data follows RAM with no register in between
        req_wr = 1'b0; req_ind = 1'b0; dir_off = 7'h71; dir_bank = 2'd2;
        @(negedge clk);
        ram_rdata = 8'hC3;
        #1;
        chk("R9 pass-through", 32'(rd_data), 32'hC3);
        chk("R3 shared from bank2", 32'(map_addr), 32'h071);

        // R7: dropping the request clears the outputs
        idle_inputs();
        @(negedge clk);
        chk("R7 idle after traffic", {29'b0, map_vld, map_hit, ram_we}, 0);
        chk("R5/R9 idle rd_data", 32'(rd_data), 0);

        // R8: asynchronous reset with a pending hit
        req_vld = 1'b1; req_wr = 1'b1; dir_off = 7'h20; dir_bank = 2'd0;
        @(negedge clk);
        chk("R6 write before reset", 32'(ram_we), 1);
        rst_n = 1'b0;
        #1;
        chk("R8 async reset", {20'b0, map_vld, map_hit, ram_we, map_addr}, 0);
        @(negedge clk);
        chk("R8 held in reset", {20'b0, map_vld, map_hit, ram_we, map_addr}, 0);
        rst_n = 1'b1;
        idle_inputs();
        @(negedge clk);
        finish_run();
    end

endmodule